// File: doc/BRIEF.md
# Windowed Block Copy Engine

This engine copies a block of bytes between a private byte buffer and an external memory. Software programs three 32-bit address and length registers and then writes a command word. The command word picks the direction of the copy and whether completion raises an interrupt. The buffer occupies a fixed window of the bus address space. The address that falls on the buffer side is checked against that window before any byte moves.

Once a command is accepted, the engine waits a fixed number of clock cycles. It then checks the window. If the check passes, it moves the bytes one at a time over a valid/ready memory master port, in ascending address order. At the end it clears its run bit and pulses a completion strobe, and it can also set a sticky interrupt status bit. A transfer that fails the window check clears the run bit without touching memory and sets an error flag. The register set is frozen while a transfer runs.

Top module: `dma_window_copier`

## Requirements
- R1: Register reads are combinational on `reg_addr_i`. Offset 0x80 returns source, 0x84 destination, 0x88 byte count, 0x8C the command bits [2:0] zero-extended, and 0x24 the interrupt status. Every other offset reads zero. All of them are zero after reset.
- R2: Command bit 0 is run. Bit 1 selects direction: 0 reads external memory at source and fills the buffer at destination; 1 reads the buffer at source and writes external memory at destination. Bit 2 enables the completion interrupt.
- R3: While run is set, writes to offsets 0x80, 0x84, 0x88 and 0x8C leave those registers unchanged.
- R4: A write to 0x8C whose bit 0 is clear changes no register and starts nothing.
- R5: The first memory request is raised DELAY_CYCLES+1 clock edges after the edge that accepts the command write.
- R6: The buffer-side address A with count N is accepted only if N > 0, A >= WIN_BASE and A + N <= WIN_BASE + BUF_BYTES, with the sum taken without wrap. Byte i of the transfer uses buffer location A - WIN_BASE + i.
- R7: A rejected transfer clears run, issues no memory request, gives no completion pulse and no interrupt, and sets `err_o`. The next accepted command write clears `err_o`.
- R8: An accepted transfer makes exactly N handshakes, with the external addresses running from the external base upward by one. A request that is not granted holds its address, direction and data until `mem_ready_i` is high.
- R9: After the last handshake, run clears and `done_o` is high for exactly one cycle. If bit 2 was set, interrupt status bit 8 (value 0x100) sets and `irq_o` goes high.
- R10: A write to offset 0x64 clears each interrupt status bit that is set in the written data, whether or not run is set. `irq_o` is high exactly when the status is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write to external memory |
| mem_addr_o | output | 32 | External byte address |
| mem_wdata_o | output | 8 | Byte written to external memory |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 8 | Byte returned for a read, valid with ready |
| done_o | output | 1 | One-cycle pulse on successful completion |
| irq_o | output | 1 | Interrupt line, high while status is nonzero |
| err_o | output | 1 | Sticky range-rejection flag |

## Verification
The hardest case to reach from the ports is the window test near its edges: a range that ends exactly at the top of the buffer, a range one byte past it, a count of zero, and an address whose end wraps past 2^32. The bench programs each of these directly and then checks that nothing reached memory. The buffer itself cannot be read from outside. Its contents are therefore checked by filling a region from external memory and copying it back out to a separate region, over a sweep of offsets, lengths, ready patterns and interrupt settings. The check that writes are locked out has to land inside a transfer, so it is issued while a long transfer is still in its start delay.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;
  localparam logic [7:0] OFF_SRC      = 8'h80;
  localparam logic [7:0] OFF_DST      = 8'h84;
  localparam logic [7:0] OFF_CNT      = 8'h88;
  localparam logic [7:0] OFF_CMD      = 8'h8C;
  localparam logic [7:0] OFF_IRQ_STAT = 8'h24;
  localparam logic [7:0] OFF_IRQ_CLR  = 8'h64;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IEN = 2;
  localparam int IRQ_DONE_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_END
  } mover_state_e;
endpackage

// File: rtl/dma_copy_regs.sv
module dma_copy_regs
  import dma_copy_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        finish_i,
  input  logic        ok_i,
  output logic [31:0] src_o,
  output logic [31:0] dst_o,
  output logic [31:0] cnt_o,
  output logic        run_o,
  output logic        dir_o,
  output logic        ien_o,
  output logic [31:0] irq_status_o,
  output logic        err_o
);
  logic [31:0] src_q, dst_q, cnt_q, irq_q, irq_d;
  logic [2:0]  cmd_q;
  logic        err_q;
  logic        dma_wr;

  assign dma_wr = we_i && !cmd_q[CMD_RUN];

  always_comb begin
    irq_d = irq_q;
    if (we_i && addr_i == OFF_IRQ_CLR) irq_d = irq_d & ~wdata_i;
    if (finish_i && ok_i && cmd_q[CMD_IEN]) irq_d[IRQ_DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
      irq_q <= '0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (finish_i) begin
        cmd_q[CMD_RUN] <= 1'b0;
        if (!ok_i) err_q <= 1'b1;
      end
      if (dma_wr) begin
        case (addr_i)
          OFF_SRC: src_q <= wdata_i;
          OFF_DST: dst_q <= wdata_i;
          OFF_CNT: cnt_q <= wdata_i;
          OFF_CMD: if (wdata_i[CMD_RUN]) begin
            cmd_q <= wdata_i[2:0];
            err_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFF_SRC:      rdata_o = src_q;
      OFF_DST:      rdata_o = dst_q;
      OFF_CNT:      rdata_o = cnt_q;
      OFF_CMD:      rdata_o = {29'd0, cmd_q};
      OFF_IRQ_STAT: rdata_o = irq_q;
      default:      rdata_o = '0;
    endcase
  end

  assign src_o        = src_q;
  assign dst_o        = dst_q;
  assign cnt_o        = cnt_q;
  assign run_o        = cmd_q[CMD_RUN];
  assign dir_o        = cmd_q[CMD_DIR];
  assign ien_o        = cmd_q[CMD_IEN];
  assign irq_status_o = irq_q;
  assign err_o        = err_q;
endmodule

// File: rtl/dma_window_chk.sv
module dma_window_chk #(
  parameter logic [31:0] WIN_BASE  = 32'h0004_0000,
  parameter int unsigned BUF_BYTES = 4096
) (
  input  logic [31:0] addr_i,
  input  logic [31:0] cnt_i,
  output logic        ok_o
);
  localparam logic [32:0] WIN_END = {1'b0, WIN_BASE} + 33'(BUF_BYTES);

  logic [32:0] end_w;
  assign end_w = {1'b0, addr_i} + {1'b0, cnt_i};
  // 33-bit sum so a wrapping range cannot alias into the window
  assign ok_o = (cnt_i != '0) && (addr_i >= WIN_BASE) && (end_w <= WIN_END);
endmodule

// File: rtl/dma_copy_buf.sv
module dma_copy_buf #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dma_copy_mover.sv
module dma_copy_mover
  import dma_copy_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 1000,
  parameter int unsigned AW           = 12,
  parameter logic [31:0] WIN_BASE     = 32'h0004_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          dir_i,
  input  logic [31:0]   src_i,
  input  logic [31:0]   dst_i,
  input  logic [AW:0]   cnt_i,
  input  logic          win_ok_i,
  output logic          finish_o,
  output logic          ok_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          buf_we_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [7:0]    buf_wdata_o,
  input  logic [7:0]    buf_rdata_i
);
  localparam int unsigned DW = $clog2(DELAY_CYCLES + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(DELAY_CYCLES - 1);

  mover_state_e state_q;
  logic [DW-1:0] dcnt_q;
  logic [AW:0]   idx_q;
  logic          ok_q;
  logic          hs, last;
  logic [31:0]   ext_base;
  logic [AW-1:0] buf_base;

  assign ext_base = dir_i ? dst_i : src_i;
  assign buf_base = AW'(dir_i ? src_i : dst_i) - AW'(WIN_BASE);
  assign hs       = (state_q == ST_XFER) && mem_ready_i;
  assign last     = (idx_q + 1'b1) == cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      idx_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (run_i) begin
          state_q <= ST_WAIT;
          dcnt_q  <= '0;
        end
        ST_WAIT: if (dcnt_q == DLY_LAST) begin
          idx_q   <= '0;
          ok_q    <= win_ok_i;
          state_q <= win_ok_i ? ST_XFER : ST_END;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
        ST_XFER: if (hs) begin
          if (last) state_q <= ST_END;
          else      idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign finish_o    = (state_q == ST_END);
  assign ok_o        = ok_q;
  assign mem_req_o   = (state_q == ST_XFER);
  assign mem_we_o    = mem_req_o && dir_i;
  assign mem_addr_o  = ext_base + 32'(idx_q);
  assign mem_wdata_o = buf_rdata_i;
  assign buf_addr_o  = buf_base + idx_q[AW-1:0];
  assign buf_we_o    = hs && !dir_i;
  assign buf_wdata_o = mem_rdata_i;
endmodule

// File: rtl/dma_window_copier.sv
module dma_window_copier #(
  parameter int unsigned BUF_BYTES    = 4096,
  parameter logic [31:0] WIN_BASE     = 32'h0004_0000,
  parameter int unsigned DELAY_CYCLES = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic        mem_ready_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        done_o,
  output logic        irq_o,
  output logic        err_o
);
  localparam int unsigned AW = $clog2(BUF_BYTES);

  logic [31:0]   src_w, dst_w, cnt_w, irq_status_w;
  logic          run_w, dir_w, ien_w, win_ok_w, finish_w, ok_w;
  logic          buf_we_w;
  logic [AW-1:0] buf_addr_w;
  logic [7:0]    buf_wdata_w, buf_rdata_w;

  dma_copy_regs i_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .finish_i    (finish_w),
    .ok_i        (ok_w),
    .src_o       (src_w),
    .dst_o       (dst_w),
    .cnt_o       (cnt_w),
    .run_o       (run_w),
    .dir_o       (dir_w),
    .ien_o       (ien_w),
    .irq_status_o(irq_status_w),
    .err_o       (err_o)
  );

  dma_window_chk #(.WIN_BASE(WIN_BASE), .BUF_BYTES(BUF_BYTES)) i_win (
    .addr_i(dir_w ? src_w : dst_w),
    .cnt_i (cnt_w),
    .ok_o  (win_ok_w)
  );

  dma_copy_mover #(.DELAY_CYCLES(DELAY_CYCLES), .AW(AW), .WIN_BASE(WIN_BASE)) i_mover (
    .clk_i, .rst_ni,
    .run_i      (run_w),
    .dir_i      (dir_w),
    .src_i      (src_w),
    .dst_i      (dst_w),
    .cnt_i      (cnt_w[AW:0]),
    .win_ok_i   (win_ok_w),
    .finish_o   (finish_w),
    .ok_o       (ok_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .buf_we_o   (buf_we_w),
    .buf_addr_o (buf_addr_w),
    .buf_wdata_o(buf_wdata_w),
    .buf_rdata_i(buf_rdata_w)
  );

  dma_copy_buf #(.DEPTH(BUF_BYTES), .AW(AW)) i_buf (
    .clk_i,
    .we_i   (buf_we_w),
    .waddr_i(buf_addr_w),
    .wdata_i(buf_wdata_w),
    .raddr_i(buf_addr_w),
    .rdata_o(buf_rdata_w)
  );

  assign done_o = finish_w && ok_w;
  assign irq_o  = |irq_status_w;
endmodule

// File: rtl/dma_window_copier_chk.sv
module dma_window_copier_chk
  import dma_copy_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [7:0]  reg_addr_i,
  input logic        run_i,
  input logic        ien_i,
  input logic [31:0] src_i,
  input logic [31:0] irq_status_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ready_i,
  input logic        done_o,
  input logic        err_o
);
  a_r3_src_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && reg_we_i && reg_addr_i == OFF_SRC) |=> src_i == $past(src_i));

  a_r7_req_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> run_i);

  a_r7_err_without_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !$past(done_o));

  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r9_run_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !run_i);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ien_i) |=> irq_status_i[IRQ_DONE_BIT]);
endmodule

bind dma_window_copier dma_window_copier_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .run_i       (run_w),
  .ien_i       (ien_w),
  .src_i       (src_w),
  .irq_status_i(irq_status_w),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_dma_window_copier.sv
`timescale 1ns/1ps
module test_dma_window_copier;
  localparam int DLY = 5;
  localparam logic [31:0] WB = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i = 8'h00;
  logic        done_o, irq_o, err_o;

  dma_window_copier #(.DELAY_CYCLES(DLY)) i_dma_window_copier (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .done_o, .irq_o, .err_o
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, c0 = 0;
  int n_acc, n_we, order_err, first_req, done_cnt, rdy_mode = 0;
  logic [31:0] exp_addr;
  logic [7:0] ext_mem [4096];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial forever @(posedge clk) cyc++;

  // memory model and handshake monitor
  initial forever begin
    @(negedge clk);
    mem_ready_i = (rdy_mode == 0) ? 1'b1 : ((cyc % (rdy_mode + 1)) != 0);
    mem_rdata_i = ext_mem[mem_addr_o[11:0]];
    if (done_o) done_cnt++;
    if (mem_req_o && first_req < 0) first_req = cyc;
    if (mem_req_o && mem_ready_i) begin
      if (mem_addr_o != exp_addr) order_err++;
      exp_addr++;
      n_acc++;
      if (mem_we_o) begin
        n_we++;
        ext_mem[mem_addr_o[11:0]] = mem_wdata_o;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; c0 = cyc;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic clr_mon(input logic [31:0] base);
    n_acc = 0; n_we = 0; order_err = 0; first_req = -1; done_cnt = 0; exp_addr = base;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd(8'h8C, v);
      if (!v[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic start(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
                       input logic [31:0] cmd);
    wr(8'h80, s); wr(8'h84, d); wr(8'h88, n);
    clr_mon(cmd[1] ? d : s);
    wr(8'h8C, cmd);
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed * 13 + 3) & 8'hFF);
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int offs [5] = '{0, 5, 12'hFF0, 12'h123, 12'h7FF};
    int cnts [5] = '{1, 7, 16, 33, 64};
    logic [31:0] rej_a [5] = '{32'h3FFFF, 32'h40FFF, 32'h40000, 32'hFFFFFFFF, 32'h41000};
    logic [31:0] rej_n [5] = '{4, 2, 0, 2, 1};
    for (int i = 0; i < 4096; i++) ext_mem[i] = 8'h00;
    clr_mon(0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h80, v); chk(v == 0, "R1 reset src", v, 0);
    rd(8'h84, v); chk(v == 0, "R1 reset dst", v, 0);
    rd(8'h88, v); chk(v == 0, "R1 reset cnt", v, 0);
    rd(8'h8C, v); chk(v == 0, "R1 reset cmd", v, 0);
    rd(8'h24, v); chk(v == 0, "R1 reset irq status", v, 0);
    chk(!irq_o && !err_o && !mem_req_o, "R1 reset outputs", {irq_o, err_o, mem_req_o}, 0);

    // R1 readback
    wr(8'h80, 32'h1234_5678); wr(8'h84, 32'h9ABC_DEF0); wr(8'h88, 32'h0000_0F0F);
    rd(8'h80, v); chk(v == 32'h1234_5678, "R1 src readback", v, 32'h1234_5678);
    rd(8'h84, v); chk(v == 32'h9ABC_DEF0, "R1 dst readback", v, 32'h9ABC_DEF0);
    rd(8'h88, v); chk(v == 32'h0000_0F0F, "R1 cnt readback", v, 32'h0F0F);
    rd(8'h00, v); chk(v == 0, "R1 unmapped offset", v, 0);

    // R4 command write without run bit
    clr_mon(0);
    wr(8'h8C, 32'h0000_0006);
    rd(8'h8C, v); chk(v == 0, "R4 cmd unchanged", v, 0);
    repeat (DLY + 6) @(negedge clk);
    chk(first_req < 0 && n_acc == 0, "R4 no request", n_acc, 0);

    // sweep: fill buffer from external memory, copy it back out
    for (int t = 0; t < 5; t++) begin
      int ien = t % 2;
      logic [31:0] cmd_in = 32'h1 | (ien << 2);
      int bad = 0;
      for (int i = 0; i < cnts[t]; i++) begin
        ext_mem[12'h100 + i] = pat(i, t);
        ext_mem[12'h800 + i] = 8'hA5 ^ pat(i, t);
      end
      rdy_mode = t;
      start(32'h100, WB + offs[t], cnts[t], cmd_in);
      rd(8'h8C, v); chk(v == cmd_in, "R2 cmd readback while running", v, cmd_in);
      wait_idle();
      chk(first_req - c0 == DLY + 2, "R5 start delay", first_req - c0, DLY + 2);
      chk(n_acc == cnts[t] && order_err == 0, "R8 read handshakes in order", n_acc, cnts[t]);
      chk(n_we == 0, "R2 direction 0 only reads", n_we, 0);
      chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
      rd(8'h24, v);
      chk(v == (ien ? 32'h100 : 0), "R9 irq status", v, ien ? 32'h100 : 0);
      chk(irq_o == ien[0], "R10 irq line", irq_o, ien);
      if (ien) begin
        wr(8'h64, 32'h1);
        rd(8'h24, v); chk(v == 32'h100, "R10 clear other bit keeps status", v, 32'h100);
        wr(8'h64, 32'h100);
        rd(8'h24, v); chk(v == 0 && !irq_o, "R10 clear status", v, 0);
      end
      start(WB + offs[t], 32'h800, cnts[t], 32'h3);
      wait_idle();
      chk(n_we == cnts[t] && order_err == 0, "R8 write handshakes in order", n_we, cnts[t]);
      for (int i = 0; i < cnts[t]; i++) if (ext_mem[12'h800 + i] != pat(i, t)) bad++;
      chk(bad == 0, "R6 buffer mapping round trip", bad, 0);
      chk(!err_o, "R7 no error on valid range", err_o, 0);
    end
    rdy_mode = 0;

    // R6 last byte of window accepted
    start(WB + 32'hFFF, 32'h900, 1, 32'h3);
    wait_idle();
    chk(n_acc == 1 && !err_o, "R6 last byte accepted", n_acc, 1);

    // R6 R7 rejected ranges
    for (int t = 0; t < 5; t++) begin
      logic [31:0] cmd = (t % 2) ? 32'h7 : 32'h5;
      if (t % 2) start(rej_a[t], 32'h900, rej_n[t], cmd);
      else       start(32'h100, rej_a[t], rej_n[t], cmd);
      wait_idle();
      @(negedge clk);
      chk(n_acc == 0 && first_req < 0, "R7 rejected makes no request", n_acc, 0);
      chk(done_cnt == 0, "R7 rejected no done", done_cnt, 0);
      chk(err_o, "R7 error flag", err_o, 1);
      rd(8'h24, v); chk(v == 0 && !irq_o, "R7 rejected no irq", v, 0);
      rd(8'h8C, v); chk(v == (cmd & 32'h6), "R7 run cleared", v, cmd & 32'h6);
    end

    // R7 error cleared by accepted command; R3 lockout while running
    wr(8'h80, 32'h100); wr(8'h84, WB); wr(8'h88, 32'd4);
    clr_mon(32'h100);
    wr(8'h8C, 32'h1);
    chk(!err_o, "R7 error cleared on accept", err_o, 0);
    wr(8'h80, 32'hDEAD_BEEF);
    wr(8'h88, 32'd9);
    wr(8'h8C, 32'h3);
    rd(8'h80, v); chk(v == 32'h100, "R3 src locked", v, 32'h100);
    rd(8'h88, v); chk(v == 4, "R3 cnt locked", v, 4);
    rd(8'h8C, v); chk(v == 1, "R3 cmd locked", v, 1);
    wait_idle();
    chk(n_acc == 4 && n_we == 0, "R3 transfer kept its setup", n_acc, 4);

    finish_run();
  end
endmodule